// File: doc/BRIEF.md
# Two-Phase Digital Regulator Loop Controller

This block is the digital loop of a regulator built from switched power transistors. A single comparator decision bit comes in. It is high when the regulated output is below its reference. Two groups of transistor enable lines go out. The first phase is a binary search over an 8-bit code that drives the large, binary-weighted devices. That search brings the output close to the target.

After the search the code is frozen. A second phase then trims with a bank of 80 small unit devices. That bank is held as a thermometer pattern. Each cycle it grows or shrinks by one device, following the comparator. The trim bank starts from its middle position, so it can correct in either direction. This leaves room to absorb process spread after the coarse search.

The comparator bit is asynchronous to the loop clock, so it is resynchronized before use. A synchronous reset or a restart pulse begins a new coarse search.

Top module: `dldo_ctrl`

## Requirements
- R1: The comparator bit passes through two flip-flops before use. The decision applied at a clock edge is the `cmp_low` value that was sampled two edges earlier.
- R2: While `rst` is high, the state after each clock edge is as follows: `coarse_code` = 8'h80 (only the trial bit is on), `coarse_done` = 0, and `fine_en` has exactly bits 39..0 set. The synchronizer flops are also cleared.
- R3: The coarse search tests bits from bit 7 down to bit 0, one bit per clock. During the search, `coarse_code` shows the bits already decided plus the bit now on trial. A tested bit is kept when the decision is 1 (output low) and cleared when it is 0.
- R4: `coarse_done` rises on the edge that applies the eighth decision, and not before. From then on, `coarse_code` equals the eight kept decisions and stays unchanged until `rst` or `restart`.
- R5: While `coarse_done` is 0, `fine_en` holds its midpoint pattern (bits 39..0 set).
- R6: While `coarse_done` is 1, each edge changes the trim bank by one stage. A decision of 1 sets the lowest cleared bit of `fine_en`. A decision of 0 clears the highest set bit.
- R7: The trim bank saturates. A decision of 1 with all 80 bits set leaves `fine_en` unchanged. A decision of 0 with no bit set leaves it unchanged.
- R8: A `restart` held at an edge puts the code, the done flag and the trim bank into the R2 state. It does not clear the synchronizer, and it does not affect a search that has not yet seen `restart`.
- R9: `fine_en` is always a thermometer pattern with its set bits contiguous from bit 0. Outside reset or restart, no more than one of its bits changes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Begin a new coarse search; trim bank back to midpoint |
| cmp_low | input | 1 | Comparator decision, 1 = output below reference (asynchronous) |
| coarse_code | output | 8 | Enables for the binary-weighted large devices |
| fine_en | output | 80 | Thermometer enables for the unit trim devices |
| coarse_done | output | 1 | High once the coarse search has finished |

## Verification
Some properties are checked on every cycle. The trim bank always keeps its thermometer shape and moves at most one stage per clock. It stays parked at midpoint during the search. The coarse code never moves once the search is finished. The done flag agrees with an independent count of decisions since reset or restart. Other behaviour only the bench scenarios can show: that each decision lands exactly two edges after the comparator changes, that the kept bits match a chosen decision pattern, and that the trim count saturates at both ends and comes back from them.

// File: rtl/dldo_pkg.sv
package dldo_pkg;

    localparam int DLDO_CODE_W   = 8;
    localparam int DLDO_FINE_N   = 80;
    localparam int DLDO_FINE_MID = 40;
    localparam int DLDO_SYNC_N   = 2;

    typedef enum logic {
        PH_COARSE = 1'b0,
        PH_FINE   = 1'b1
    } loop_phase_e;

    typedef enum logic [1:0] {
        TRIM_HOLD = 2'd0,
        TRIM_UP   = 2'd1,
        TRIM_DOWN = 2'd2
    } trim_cmd_e;

    // Select a trim command from the phase, the decision and the saturation flags.
    function automatic trim_cmd_e trim_pick(input loop_phase_e ph, input logic want_up,
                                            input logic full, input logic empty);
        trim_cmd_e cmd;
        cmd = TRIM_HOLD;
        if (ph == PH_FINE) begin
            if (want_up && !full)
                cmd = TRIM_UP;
            else if (!want_up && !empty)
                cmd = TRIM_DOWN;
        end
        return cmd;
    endfunction

endpackage

// File: rtl/dldo_sync.sv
module dldo_sync #(
    parameter int STAGES = dldo_pkg::DLDO_SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/dldo_sar.sv
module dldo_sar #(
    parameter int W = dldo_pkg::DLDO_CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         dec_low,
    output logic [W-1:0] code,
    output logic         done
);
    localparam logic [W-1:0] TRIAL_FIRST = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] kept_q;
    logic [W-1:0] trial_q;
    logic         done_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            kept_q  <= '0;
            trial_q <= TRIAL_FIRST;
            done_q  <= 1'b0;
        end else if (!done_q) begin
            if (dec_low)
                kept_q <= kept_q | trial_q;
            trial_q <= trial_q >> 1;
            if (trial_q[0])
                done_q <= 1'b1;
        end
    end

    assign code = kept_q | trial_q;
    assign done = done_q;
endmodule

// File: rtl/dldo_trim.sv
module dldo_trim #(
    parameter int N   = dldo_pkg::DLDO_FINE_N,
    parameter int MID = dldo_pkg::DLDO_FINE_MID
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  dldo_pkg::trim_cmd_e cmd,
    output logic [N-1:0]        en,
    output logic                full,
    output logic                empty
);
    import dldo_pkg::*;

    localparam logic [N-1:0] MID_PATTERN = {{(N-MID){1'b0}}, {MID{1'b1}}};

    logic [N-1:0] en_q;
    logic [N-1:0] en_next;

    // Each stage takes its lower neighbour when growing and its upper one when shrinking.
    for (genvar g = 0; g < N; g++) begin : g_stage
        if (g == 0) begin : g_bottom
            always_comb begin
                unique case (cmd)
                    TRIM_UP:   en_next[g] = 1'b1;
                    TRIM_DOWN: en_next[g] = en_q[g+1];
                    default:   en_next[g] = en_q[g];
                endcase
            end
        end else if (g == N-1) begin : g_top
            always_comb begin
                unique case (cmd)
                    TRIM_UP:   en_next[g] = en_q[g-1];
                    TRIM_DOWN: en_next[g] = 1'b0;
                    default:   en_next[g] = en_q[g];
                endcase
            end
        end else begin : g_mid
            always_comb begin
                unique case (cmd)
                    TRIM_UP:   en_next[g] = en_q[g-1];
                    TRIM_DOWN: en_next[g] = en_q[g+1];
                    default:   en_next[g] = en_q[g];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            en_q <= MID_PATTERN;
        else
            en_q <= en_next;
    end

    assign en    = en_q;
    assign full  = en_q[N-1];
    assign empty = !en_q[0];
endmodule

// File: rtl/dldo_ctrl.sv
module dldo_ctrl #(
    parameter int CODE_W   = dldo_pkg::DLDO_CODE_W,
    parameter int FINE_N   = dldo_pkg::DLDO_FINE_N,
    parameter int FINE_MID = dldo_pkg::DLDO_FINE_MID
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              cmp_low,
    output logic [CODE_W-1:0] coarse_code,
    output logic [FINE_N-1:0] fine_en,
    output logic              coarse_done
);
    import dldo_pkg::*;

    logic        dec_low;
    logic        sar_done;
    logic        trim_full;
    logic        trim_empty;
    loop_phase_e phase;
    trim_cmd_e   cmd;

    dldo_sync #(.STAGES(DLDO_SYNC_N)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  (cmp_low),
        .q_out (dec_low)
    );

    dldo_sar #(.W(CODE_W)) sar_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .dec_low (dec_low),
        .code    (coarse_code),
        .done    (sar_done)
    );

    assign phase = sar_done ? PH_FINE : PH_COARSE;
    assign cmd   = trim_pick(phase, dec_low, trim_full, trim_empty);

    dldo_trim #(.N(FINE_N), .MID(FINE_MID)) trim_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .cmd     (cmd),
        .en      (fine_en),
        .full    (trim_full),
        .empty   (trim_empty)
    );

    assign coarse_done = sar_done;
endmodule

// File: rtl/dldo_ctrl_chk.sv
module dldo_ctrl_chk #(
    parameter int CODE_W   = 8,
    parameter int FINE_N   = 80,
    parameter int FINE_MID = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              restart,
    input logic [CODE_W-1:0] coarse_code,
    input logic [FINE_N-1:0] fine_en,
    input logic              coarse_done
);
    localparam int CW = $clog2(CODE_W + 1);
    localparam logic [FINE_N-1:0] MIDP = {{(FINE_N-FINE_MID){1'b0}}, {FINE_MID{1'b1}}};
    localparam logic [CODE_W-1:0] MSB1 = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CW-1:0] dec_cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            dec_cnt <= '0;
        else if (dec_cnt != CW'(CODE_W))
            dec_cnt <= dec_cnt + CW'(1);
    end

    // R2 / R8: state after a reset or restart edge
    assert_init_state_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) || $past(restart)) |->
            (coarse_code == MSB1 && !coarse_done && fine_en == MIDP));

    // R4: done agrees with the count of decisions taken
    assert_done_count_R4: assert property (@(posedge clk) disable iff (rst)
        coarse_done == (dec_cnt == CW'(CODE_W)));

    // R4: code frozen after the search
    assert_code_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (coarse_done && !restart) |=> $stable(coarse_code));

    // R5: trim parked during the search
    assert_trim_parked_R5: assert property (@(posedge clk) disable iff (rst)
        (!coarse_done && !restart) |=> $stable(fine_en));

    // R9: thermometer shape
    assert_thermo_shape_R9: assert property (@(posedge clk) disable iff (rst)
        (fine_en & (fine_en + FINE_N'(1))) == '0);

    // R9: one stage per clock
    assert_single_step_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(restart)) |-> ($countones(fine_en ^ $past(fine_en)) <= 1));
endmodule

bind dldo_ctrl dldo_ctrl_chk #(
    .CODE_W   (CODE_W),
    .FINE_N   (FINE_N),
    .FINE_MID (FINE_MID)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .restart     (restart),
    .coarse_code (coarse_code),
    .fine_en     (fine_en),
    .coarse_done (coarse_done)
);

// File: tb/dldo_ctrl_tb_top.sv
module dldo_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int MID = 40;

    localparam logic [7:0] VEC_D  [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};
    localparam int         VEC_UP [NV] = '{3, 0, 45, 0, 10, 42};
    localparam int         VEC_DN [NV] = '{0, 5, 0, 45, 10, 3};
    localparam int         VEC_FIN[NV] = '{43, 35, 80, 0, 40, 77};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        restart = 1'b0;
    logic        cmp_low = 1'b0;
    logic [7:0]  coarse_code;
    logic [79:0] fine_en;
    logic        coarse_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dldo_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .restart     (restart),
        .cmp_low     (cmp_low),
        .coarse_code (coarse_code),
        .fine_en     (fine_en),
        .coarse_done (coarse_done)
    );

    function automatic logic [79:0] therm(input int n);
        logic [79:0] v = '0;
        for (int i = 0; i < n; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one vector: a restart with an 8-decision search, then a run of fine decisions.
    task automatic run_vec(input logic [7:0] d, input int nup, input int ndn, input int fin);
        int nf = nup + ndn;
        int ecnt = MID;
        logic [7:0] ecode;
        @(negedge clk); restart = 1'b1; cmp_low = d[7];
        @(negedge clk); cmp_low = d[6];
        for (int c = 2; c <= nf + 10; c++) begin
            int m = c - 2;
            @(negedge clk);
            if (c == 2) restart = 1'b0;
            if (m >= 9 && (m - 9) < nf) begin
                if ((m - 9) < nup) begin
                    if (ecnt < 80) ecnt++;
                end else begin
                    if (ecnt > 0) ecnt--;
                end
            end
            if (m <= 8)
                ecode = (d & (8'hFF << (8 - m))) | ((m < 8) ? (8'h80 >> m) : 8'h00);
            else
                ecode = d;
            chk(m <= 8 ? "R1/R3 coarse code" : "R4 frozen code", {72'b0, coarse_code}, {72'b0, ecode});
            chk("R4 done flag", {79'b0, coarse_done}, {79'b0, (m >= 8)});
            chk(m <= 8 ? "R5 trim parked" : "R6/R7/R9 trim step", fine_en, therm(ecnt));
            if (c < 8)
                cmp_low = d[7 - c];
            else
                cmp_low = ((c - 8) < nup);
        end
        chk("R6/R7 final trim count", {73'b0, 7'($countones(fine_en))}, {73'b0, 7'(fin)});
    endtask

    initial begin
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R2: state under reset
        chk("R2 reset code", {72'b0, coarse_code}, {72'b0, 8'h80});
        chk("R2 reset done", {79'b0, coarse_done}, 80'b0);
        chk("R2 reset trim", fine_en, therm(MID));
        rst = 1'b0;

        // R8: each vector starts with a restart out of the previous fine phase
        for (int v = 0; v < NV; v++) begin
            run_vec(VEC_D[v], VEC_UP[v], VEC_DN[v], VEC_FIN[v]);
            if (v == 2) begin
                // R2: reset during fine phase at full trim
                rst = 1'b1;
                @(negedge clk);
                chk("R2 mid-run reset code", {72'b0, coarse_code}, {72'b0, 8'h80});
                chk("R2 mid-run reset done", {79'b0, coarse_done}, 80'b0);
                chk("R2 mid-run reset trim", fine_en, therm(MID));
                rst = 1'b0;
            end
        end

        // R8: a single restart cycle during fine phase returns the trim bank to midpoint
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        chk("R8 restart code", {72'b0, coarse_code}, {72'b0, 8'h80});
        chk("R8 restart trim", fine_en, therm(MID));
        chk("R8 restart done", {79'b0, coarse_done}, 80'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule